// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Word Port

This block holds a small table of address translations that software fills and inspects itself. Each entry is written and read through one of three words, and each word has its own bit layout. The tag word holds the virtual page number, a page-size code, an endian attribute and a valid flag. The real word holds the physical page number. The access word holds an attribute byte and six permission flags. A write to the tag word stamps the entry with the process ID that sits in the low byte of a control register inside the block. Reading the tag word with the read strobe copies the entry's ID back into that byte.

When a write lands on an entry that is still live and owned by a current ID, the block raises a flush request for that entry's old address range in the same cycle. Downstream cached translations can then be dropped. A combinational search takes a virtual address and returns the lowest matching index, or all ones when no entry matches. The search compares against the current ID.

Top module: `xlat_tlb_port`

## Requirements
- R1: After reset every entry reads as zero in all three words, and so is invalid. The control register is zero, and a search misses.
- R2: A write with word select 0 or 3 loads the tag fields of the entry at wr_index. Page number = data & 0xFFFFFC00, size code = data[7:4], endian = data[8], valid = data[9]. The entry's process ID is loaded from control[7:0]. The write takes effect at the clock edge of the strobe.
- R3: A write with word select 1 stores data & 0xFFFFFC0F as the real page number. A read with word select 1 returns it.
- R4: A write with word select 2 stores the attribute byte from data[15:8] and the permissions from data[5:0]. Bit 0/1/2 are user read/write/execute and bit 3/4/5 are supervisor read/write/execute. Valid and endian stay as they were. A read with word select 2 returns the same layout, with every other bit zero.
- R5: A read with word select 0 or 3 returns page number | valid<<9 | endian<<8 | size<<4, combinationally. With rd_en high it also copies the entry's ID into control[7:0] at the next edge and leaves control[31:8] alone. A control write in the same cycle wins.
- R6: In the cycle of a write, flush_req is 1 only when the target entry is valid and its ID equals control[7:0], or equals a nonzero alt_pid1, or equals a nonzero alt_pid2. flush_base gives that entry's page number and flush_mask gives its page mask.
- R7: Page size is 1024 << (2 × size code). The page mask is the complement of (size − 1) truncated to 32 bits, so size codes 11 to 15 give a mask of zero.
- R8: An entry matches a search when it is valid, its ID equals control[7:0], and its page number equals the search address ANDed with its page mask. srch_result gives the lowest matching index and srch_hit is 1.
- R9: With no matching entry, srch_hit is 0 and srch_result is 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Load the control register |
| ctl_wr_data | input | 32 | New control register value |
| ctl_q | output | 32 | Control register; bits 7:0 are the current process ID |
| alt_pid1 | input | 8 | First alternate ID, ignored when zero |
| alt_pid2 | input | 8 | Second alternate ID, ignored when zero |
| wr_en | input | 1 | Entry write strobe |
| wr_word | input | 2 | Word select: 0/3 tag, 1 real, 2 access |
| wr_index | input | 6 | Entry index for writes |
| wr_data | input | 32 | Write value |
| rd_en | input | 1 | Read strobe; enables the ID copy-back on tag reads |
| rd_word | input | 2 | Word select for reads |
| rd_index | input | 6 | Entry index for reads |
| rd_data | output | 32 | Selected word of the selected entry |
| srch_addr | input | 32 | Virtual address to search |
| srch_hit | output | 1 | Some entry matches |
| srch_result | output | 32 | Matching index, or all ones |
| flush_req | output | 1 | The write in progress replaces a live owned entry |
| flush_base | output | 32 | Old page number of that entry |
| flush_mask | output | 32 | Old page mask of that entry |

## Verification
The bench sweeps all sixteen size codes through the flush mask. This catches a mask that wraps instead of reaching zero at the large codes: such a design would let huge pages match the wrong addresses. It places two identical live entries at different indices to expose a priority encoder that picks the highest index. It drives the alternate IDs with zero against an entry whose ID is zero, so that a design which does not ignore zero alternates raises spurious flushes. It also checks that an access-word write keeps the valid and endian flags, and that a control write beats the copy-back from a tag read.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

  localparam int XW      = 32;
  localparam int PG_LSB  = 10;
  localparam int EPN_W   = XW - PG_LSB;
  localparam logic [XW-1:0] REAL_KEEP = 32'hFFFF_FC0F;

  typedef struct packed {
    logic [EPN_W-1:0] epn;
    logic [3:0]       szc;
    logic             valid;
    logic [7:0]       pid;
  } tlb_key_t;

  typedef struct packed {
    tlb_key_t     key;
    logic         endian;
    logic [XW-1:0] rpn;
    logic [7:0]   attr;
    logic [5:0]   perm;
  } tlb_ent_t;

  typedef enum logic [1:0] {
    WSEL_TAG   = 2'd0,
    WSEL_REAL  = 2'd1,
    WSEL_ACC   = 2'd2,
    WSEL_TAG_B = 2'd3
  } wsel_e;

  // mask that keeps the page-number bits of an address for a size code
  function automatic logic [XW-1:0] page_mask(input logic [3:0] szc);
    logic [5:0] sh;
    sh = 6'(PG_LSB) + {1'b0, szc, 1'b0};
    if (sh >= 6'(XW)) return '0;
    return ~((32'd1 << sh) - 32'd1);
  endfunction

  function automatic logic [XW-1:0] tag_word(input tlb_ent_t e);
    return {e.key.epn, e.key.valid, e.endian, e.key.szc, 4'b0000};
  endfunction

  function automatic logic [XW-1:0] acc_word(input tlb_ent_t e);
    return {16'h0000, e.attr, 2'b00, e.perm};
  endfunction

  function automatic logic owner_hit(input logic [7:0] epid, input logic [7:0] cur,
                                     input logic [7:0] a1, input logic [7:0] a2);
    return (epid == cur) || ((a1 != 8'h00) && (epid == a1)) ||
           ((a2 != 8'h00) && (epid == a2));
  endfunction

  function automatic tlb_ent_t apply_word(input tlb_ent_t e, input logic [1:0] w,
                                          input logic [XW-1:0] d, input logic [7:0] pid);
    tlb_ent_t n;
    n = e;
    case (wsel_e'(w))
      WSEL_REAL: n.rpn = d & REAL_KEEP;
      WSEL_ACC: begin
        n.attr = d[15:8];
        n.perm = d[5:0];
      end
      default: begin
        n.key.epn   = d[XW-1:PG_LSB];
        n.key.szc   = d[7:4];
        n.endian    = d[8];
        n.key.valid = d[9];
        n.key.pid   = pid;
      end
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import xlat_tlb_pkg::*;
#(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_word,
  input  logic [IW-1:0]        wr_idx,
  input  logic [XW-1:0]        wr_data,
  input  logic [7:0]           cur_pid,
  output tlb_ent_t [N-1:0]     ents_o,
  output tlb_key_t [N-1:0]     keys_o
);

  for (genvar i = 0; i < N; i++) begin : g_ent
    tlb_ent_t ent_q;
    logic     sel;
    assign sel = wr_en && (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent_q <= '0;
      else if (sel) ent_q <= apply_word(ent_q, wr_word, wr_data, cur_pid);
    end
    assign ents_o[i] = ent_q;
    assign keys_o[i] = ent_q.key;
  end

  // R2: tag write sets valid from data bit 9 at the strobe edge
  assert_tag_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_word == 2'd0 || wr_word == 2'd3) |=>
      keys_o[$past(wr_idx)].valid == $past(wr_data[9]));

  // R4: access write leaves valid and endian alone
  assert_acc_keeps_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_word == 2'd2 |=>
      (ents_o[$past(wr_idx)].key.valid == $past(ents_o[wr_idx].key.valid)) &&
      (ents_o[$past(wr_idx)].endian == $past(ents_o[wr_idx].endian)));

endmodule

// File: rtl/tlb_search.sv
module tlb_search
  import xlat_tlb_pkg::*;
#(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  tlb_key_t [N-1:0] keys,
  input  logic [XW-1:0]    addr,
  input  logic [7:0]       pid,
  output logic             hit,
  output logic [IW-1:0]    idx
);

  logic [N-1:0] hit_v;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_v[i] = keys[i].valid && (keys[i].pid == pid) &&
                      ({keys[i].epn, {PG_LSB{1'b0}}} == (addr & page_mask(keys[i].szc)));
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_v[i]) idx = IW'(i);
    end
  end

  assign hit = |hit_v;

endmodule

// File: rtl/tlb_read_port.sv
module tlb_read_port
  import xlat_tlb_pkg::*;
#(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  tlb_ent_t [N-1:0] ents,
  input  logic [1:0]       rd_word,
  input  logic [IW-1:0]    rd_idx,
  output logic [XW-1:0]    rd_data,
  output logic [7:0]       rd_pid
);

  tlb_ent_t cur;
  assign cur    = ents[rd_idx];
  assign rd_pid = cur.key.pid;

  always_comb begin
    case (wsel_e'(rd_word))
      WSEL_REAL: rd_data = cur.rpn;
      WSEL_ACC:  rd_data = acc_word(cur);
      default:   rd_data = tag_word(cur);
    endcase
  end

endmodule

// File: rtl/tlb_flush_check.sv
module tlb_flush_check
  import xlat_tlb_pkg::*;
#(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  tlb_key_t [N-1:0] keys,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [7:0]       cur_pid,
  input  logic [7:0]       alt1,
  input  logic [7:0]       alt2,
  output logic             flush_req,
  output logic [XW-1:0]    flush_base,
  output logic [XW-1:0]    flush_mask
);

  tlb_key_t victim;
  assign victim     = keys[wr_idx];
  assign flush_req  = wr_en && victim.valid && owner_hit(victim.pid, cur_pid, alt1, alt2);
  assign flush_base = {victim.epn, {PG_LSB{1'b0}}};
  assign flush_mask = page_mask(victim.szc);

endmodule

// File: rtl/xlat_tlb_port.sv
module xlat_tlb_port
  import xlat_tlb_pkg::*;
#(
  parameter  int ENTRIES = 64,
  localparam int IW      = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr_en,
  input  logic [31:0]   ctl_wr_data,
  output logic [31:0]   ctl_q,
  input  logic [7:0]    alt_pid1,
  input  logic [7:0]    alt_pid2,
  input  logic          wr_en,
  input  logic [1:0]    wr_word,
  input  logic [IW-1:0] wr_index,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_word,
  input  logic [IW-1:0] rd_index,
  output logic [31:0]   rd_data,
  input  logic [31:0]   srch_addr,
  output logic          srch_hit,
  output logic [31:0]   srch_result,
  output logic          flush_req,
  output logic [31:0]   flush_base,
  output logic [31:0]   flush_mask
);

  tlb_ent_t [ENTRIES-1:0] ents;
  tlb_key_t [ENTRIES-1:0] keys;
  logic [7:0]             rd_pid;
  logic [IW-1:0]          srch_idx;
  logic                   tag_read;

  assign tag_read = rd_en && (rd_word == 2'd0 || rd_word == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctl_q <= '0;
    else if (ctl_wr_en) ctl_q <= ctl_wr_data;
    else if (tag_read)  ctl_q[7:0] <= rd_pid;
  end

  tlb_entry_store #(.N(ENTRIES), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .wr_idx(wr_index), .wr_data(wr_data), .cur_pid(ctl_q[7:0]),
    .ents_o(ents), .keys_o(keys)
  );

  tlb_read_port #(.N(ENTRIES), .IW(IW)) u_rd (
    .ents(ents), .rd_word(rd_word), .rd_idx(rd_index),
    .rd_data(rd_data), .rd_pid(rd_pid)
  );

  tlb_search #(.N(ENTRIES), .IW(IW)) u_srch (
    .keys(keys), .addr(srch_addr), .pid(ctl_q[7:0]),
    .hit(srch_hit), .idx(srch_idx)
  );

  tlb_flush_check #(.N(ENTRIES), .IW(IW)) u_flush (
    .keys(keys), .wr_en(wr_en), .wr_idx(wr_index), .cur_pid(ctl_q[7:0]),
    .alt1(alt_pid1), .alt2(alt_pid2), .flush_req(flush_req),
    .flush_base(flush_base), .flush_mask(flush_mask)
  );

  assign srch_result = srch_hit ? {{(XW-IW){1'b0}}, srch_idx} : '1;

  // R5: a strobed tag read hands the entry's ID to the control low byte
  assert_pid_copyback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tag_read && !ctl_wr_en |=>
      (ctl_q[7:0] == $past(keys[rd_index].pid)) && (ctl_q[31:8] == $past(ctl_q[31:8])));

  // R8: a reported hit names a live entry owned by the current ID
  assert_hit_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |-> keys[srch_idx].valid && (keys[srch_idx].pid == ctl_q[7:0]));

  // R6: a flush names the entry being written while it is live
  assert_flush_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> wr_en && keys[wr_index].valid);

endmodule

// File: tb/xlat_tlb_port_bench.sv
`timescale 1ns/1ps
module xlat_tlb_port_bench;
  localparam int IW = 6;

  logic clk = 0, rst_n = 0;
  logic ctl_wr_en = 0; logic [31:0] ctl_wr_data = 0; logic [31:0] ctl_q;
  logic [7:0] alt_pid1 = 0, alt_pid2 = 0;
  logic wr_en = 0; logic [1:0] wr_word = 0; logic [IW-1:0] wr_index = 0; logic [31:0] wr_data = 0;
  logic rd_en = 0; logic [1:0] rd_word = 0; logic [IW-1:0] rd_index = 0; logic [31:0] rd_data;
  logic [31:0] srch_addr = 0; logic srch_hit; logic [31:0] srch_result;
  logic flush_req; logic [31:0] flush_base, flush_mask;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic fl_req; logic [31:0] fl_base, fl_mask;

  always #2 clk = ~clk;

  xlat_tlb_port u_xlat_tlb_port (.*);

  function automatic logic [7:0] pidf(int i); return 8'((i * 7 + 3) & 255); endfunction
  function automatic logic [31:0] emask(int s);
    logic [63:0] ps, m;
    ps = 64'd1024 << (2 * s);
    m  = ~(ps - 64'd1);
    return m[31:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctl(logic [31:0] v);
    @(negedge clk); ctl_wr_en = 1; ctl_wr_data = v;
    @(posedge clk); #1 ctl_wr_en = 0;
  endtask

  task automatic wr(logic [1:0] w, int idx, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_word = w; wr_index = IW'(idx); wr_data = d;
    #1 fl_req = flush_req; fl_base = flush_base; fl_mask = flush_mask;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(logic [1:0] w, int idx, output logic [31:0] v);
    @(negedge clk); rd_word = w; rd_index = IW'(idx);
    #1 v = rd_data;
  endtask

  task automatic srch(logic [31:0] a, output logic [31:0] r);
    @(negedge clk); srch_addr = a;
    #1 r = srch_result;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, r;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int i = 0; i < 64; i++) begin
      rd(2'd0, i, v); chk("R1 tag", v, 0);
      rd(2'd1, i, v); chk("R1 real", v, 0);
      rd(2'd2, i, v); chk("R1 acc", v, 0);
    end
    chk("R1 ctl", ctl_q, 0);
    srch(32'h0000_0000, r); chk("R1 search", r, 32'hFFFF_FFFF);

    // fill all entries: R2, R3, R4, R6
    for (int i = 0; i < 64; i++) begin
      logic [31:0] tagd, reald, accd;
      tagd  = (i << 22) | ((i & 1) << 8) | 32'h200 | ((i % 4) << 4) | 32'h5;
      reald = 32'hFFFF_FFFF ^ (i * 32'h0101_0101);
      accd  = 32'hABCD_00C0 | ((i ^ 32'hA5) & 32'hFF) << 8 | (i & 32'h3F);
      ctl({24'h0, pidf(i)});
      wr(2'd0, i, tagd); chk("R6 no flush on invalid", {31'b0, fl_req}, 0);
      wr(2'd1, i, reald);
      chk("R6 flush req", {31'b0, fl_req}, 1);
      chk("R6 flush base", fl_base, i << 22);
      chk("R7 flush mask", fl_mask, emask(i % 4));
      wr(2'd2, i, accd);
      rd(2'd0, i, v);
      chk("R2 tag readback", v, (i << 22) | ((i & 1) << 8) | 32'h200 | ((i % 4) << 4));
      rd(2'd3, i, r); chk("R5 alias read", r, v);
      rd(2'd1, i, v); chk("R3 real", v, reald & 32'hFFFF_FC0F);
      rd(2'd2, i, v); chk("R4 acc", v, accd & 32'h0000_FF3F);
    end

    // R5 copy-back and priority
    ctl(32'hABCD_0000);
    @(negedge clk); rd_en = 1; rd_word = 2'd0; rd_index = 6'd5;
    @(posedge clk); #1 rd_en = 0;
    chk("R5 copyback", ctl_q, {24'hABCD_00, pidf(5)});
    @(negedge clk); rd_en = 1; rd_word = 2'd3; rd_index = 6'd6;
    @(posedge clk); #1 rd_en = 0;
    chk("R5 copyback alias", ctl_q, {24'hABCD_00, pidf(6)});
    @(negedge clk); rd_en = 1; rd_word = 2'd1; rd_index = 6'd7;
    @(posedge clk); #1 rd_en = 0;
    chk("R5 no copyback real", ctl_q, {24'hABCD_00, pidf(6)});
    @(negedge clk); rd_en = 1; rd_word = 2'd0; rd_index = 6'd7;
    ctl_wr_en = 1; ctl_wr_data = 32'h1234_5678;
    @(posedge clk); #1 rd_en = 0; ctl_wr_en = 0;
    chk("R5 ctl write wins", ctl_q, 32'h1234_5678);

    // R8 hits inside each page, R9 misses
    for (int i = 0; i < 64; i++) begin
      logic [31:0] off;
      off = (32'd1024 << (2 * (i % 4))) - 32'd4;
      ctl({24'h0, pidf(i)});
      srch((i << 22) + off, r); chk("R8 hit", r, i);
      chk("R8 hit flag", {31'b0, srch_hit}, 1);
      srch((i << 22) + off + 32'd4, r); chk("R9 past page", r, 32'hFFFF_FFFF);
      chk("R9 hit flag", {31'b0, srch_hit}, 0);
    end
    ctl(32'h0000_00EE);
    srch(32'h0000_0000, r); chk("R9 foreign id", r, 32'hFFFF_FFFF);

    // R8 lowest index wins
    wr(2'd0, 40, 32'h8000_0200);
    wr(2'd0, 10, 32'h8000_0200);
    srch(32'h8000_0123, r); chk("R8 lowest wins", r, 10);
    wr(2'd0, 10, 32'h8000_0000);
    srch(32'h8000_0123, r); chk("R8 next after invalidate", r, 40);
    wr(2'd1, 10, 32'h1);
    chk("R6 invalid owned", {31'b0, fl_req}, 0);

    // R7 exhaustive size codes through flush mask
    ctl({24'h0, pidf(1)});
    for (int s = 0; s < 16; s++) begin
      wr(2'd0, 1, (1 << 22) | 32'h200 | (s << 4));
      wr(2'd1, 1, 32'h0);
      chk("R7 size mask", fl_mask, emask(s));
    end
    // R7 huge page matches anywhere; R8 through 1 GB page
    ctl({24'h0, pidf(20)});
    wr(2'd0, 20, 32'h0000_02C0);
    srch(32'hFFFF_F000, r); chk("R7 huge page", r, 20);
    ctl({24'h0, pidf(30)});
    wr(2'd0, 30, 32'h4000_02A0);
    srch(32'h7FFF_FFFF, r); chk("R7 1GB inside", r, 30);
    srch(32'h8000_0000, r); chk("R7 1GB outside", r, 32'hFFFF_FFFF);

    // R6 alternate IDs
    ctl(32'h0);
    alt_pid1 = pidf(50);
    wr(2'd1, 50, 32'h5);
    chk("R6 alt1", {31'b0, fl_req}, 1);
    chk("R6 alt1 mask", fl_mask, emask(2));
    alt_pid1 = 0; alt_pid2 = pidf(50);
    wr(2'd1, 50, 32'h6);
    chk("R6 alt2", {31'b0, fl_req}, 1);
    alt_pid2 = 0;
    wr(2'd1, 50, 32'h7);
    chk("R6 no owner", {31'b0, fl_req}, 0);
    rd(2'd1, 50, v); chk("R3 written without flush", v, 32'h7);
    wr(2'd0, 60, 32'h0123_4600);
    ctl(32'h11);
    wr(2'd1, 60, 32'h0);
    chk("R6 zero alt ignored", {31'b0, fl_req}, 0);
    ctl(32'h0);
    wr(2'd1, 60, 32'h0);
    chk("R6 primary id zero", {31'b0, fl_req}, 1);
    chk("R6 base", fl_base, 32'h0123_4400);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule